// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of one frequency-synthesizer loop. It sits behind an external dual-modulus prescaler. That prescaler divides the oscillator by P or by P+1, and its output is the clock of this block. A total ratio N arrives from the control latch. The block splits N into a swallow count A (N mod P) and a main count B (N div P).

Each division period lasts B prescaler cycles. During the first A of them the block asks for the P+1 modulus, and during the rest it asks for P. The period therefore spans exactly A(P+1) + (B−A)P = N oscillator cycles. In the last prescaler cycle of each period the block raises a one-cycle pulse for the phase detector.

The prescaler exponent is a parameter. A value of 5 gives P=32, the high band, with a legal N from 1024 up to 131071. A value of 4 gives P=16, the low band, with a legal N from 256 up to 131071. Any N below P·P is raised to P·P, so that B is never smaller than A, and an error flag reports the clamp.

A low `awake` input powers the loop down: the counter stays at its start and both outputs stay low. No data stream passes through the block. The ratio is a level that is sampled only at a period boundary, and the block applies no back-pressure to it.

Top module: `swallow_div`

## Requirements
- R1: Over every division period, the sum of the prescaler moduli selected by `mod_hi` (P+1 when high, P when low) equals the effective ratio. This holds for both P=32 and P=16.
- R2: `mod_hi` is high in exactly the first (effective N mod P) prescaler cycles of each period. It is low for the rest of the period.
- R3: `div_pulse` is high for a single clock cycle. It comes once every (effective N div P) prescaler cycles, in the last cycle of each period.
- R4: A `ratio_in` below P·P is used as P·P. While `ratio_in` is below P·P, `ratio_err` is high. For any legal ratio, `ratio_err` is low.
- R5: `ratio_in` is sampled only at the clock edge that ends a period. A change in the middle of a period leaves that period at the old ratio, and the next period uses the new one.
- R6: While `awake` is low, `mod_hi` and `div_pulse` stay low and the counter is held at its start. The first period after `awake` rises spans the full ratio presented during sleep.
- R7: While `rst_n` is low, `mod_hi` and `div_pulse` are low. Counting restarts from a fresh period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, used as the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake | input | 1 | High for normal operation, low to power the loop down |
| ratio_in | input | NW (17) | Total division ratio N from the control latch |
| mod_hi | output | 1 | Modulus select to the prescaler: 1 selects P+1, 0 selects P |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |
| ratio_err | output | 1 | High while `ratio_in` is below P·P |

## Verification
The hardest situation to reach from the ports is a ratio that changes while a period is in flight. The bench has to show that the old period still finishes at the old N before the new N appears. To get there, the bench first lines up on a pulse. It then waits a fixed number of cycles into the next period and changes `ratio_in` there. It then measures two consecutive periods against a behavioural prescaler. The same approach covers a ratio written during sleep: the bench changes `ratio_in` while `awake` is low and measures the first period after wake-up in oscillator counts.

// File: rtl/swallow_pkg.sv
`timescale 1ns/1ps
package swallow_pkg;
  localparam int RATIO_W_DEF = 17;
  localparam int PL2_HIGH_BAND = 5;
  localparam int PL2_LOW_BAND = 4;
endpackage

// File: rtl/ratio_split.sv
`timescale 1ns/1ps
module ratio_split #(
  parameter int NW  = swallow_pkg::RATIO_W_DEF,
  parameter int PL2 = swallow_pkg::PL2_HIGH_BAND
) (
  input  logic [NW-1:0]     ratio_in,
  output logic [PL2-1:0]    a_val,
  output logic [NW-PL2-1:0] b_val,
  output logic              too_low
);
  localparam int P = 1 << PL2;
  localparam logic [NW-1:0] NMIN = NW'(P * P);

  logic [NW-1:0] n_eff;

  always_comb begin
    too_low = (ratio_in < NMIN);
    n_eff   = too_low ? NMIN : ratio_in;
    a_val   = n_eff[PL2-1:0];
    b_val   = n_eff[NW-1:PL2];
  end
endmodule

// File: rtl/swallow_seq.sv
`timescale 1ns/1ps
module swallow_seq #(
  parameter int NW  = swallow_pkg::RATIO_W_DEF,
  parameter int PL2 = swallow_pkg::PL2_HIGH_BAND
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic [PL2-1:0]    a_new,
  input  logic [NW-PL2-1:0] b_new,
  output logic              run,
  output logic              last,
  output logic              swallow,
  output logic [PL2-1:0]    a_cur,
  output logic [NW-PL2-1:0] b_cur
);
  localparam int BW = NW - PL2;
  localparam int P  = 1 << PL2;

  logic          primed;
  logic [BW-1:0] cnt;

  assign run     = awake & primed;
  assign last    = (cnt == b_cur - BW'(1));
  assign swallow = (cnt < BW'(a_cur));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      cnt    <= '0;
      a_cur  <= '0;
      b_cur  <= BW'(P);
    end else begin
      primed <= 1'b1;
      if (!run || last) begin
        cnt   <= '0;
        a_cur <= a_new;
        b_cur <= b_new;
      end else begin
        cnt <= cnt + BW'(1);
      end
    end
  end
endmodule

// File: rtl/swallow_div.sv
`timescale 1ns/1ps
module swallow_div #(
  parameter int NW  = swallow_pkg::RATIO_W_DEF,
  parameter int PL2 = swallow_pkg::PL2_HIGH_BAND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          awake,
  input  logic [NW-1:0] ratio_in,
  output logic          mod_hi,
  output logic          div_pulse,
  output logic          ratio_err
);
  localparam int BW = NW - PL2;

  logic [PL2-1:0] a_new, a_cur;
  logic [BW-1:0]  b_new, b_cur;
  logic           run, last, swallow;

  ratio_split #(.NW(NW), .PL2(PL2)) u_split (
    .ratio_in (ratio_in),
    .a_val    (a_new),
    .b_val    (b_new),
    .too_low  (ratio_err)
  );

  swallow_seq #(.NW(NW), .PL2(PL2)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .awake   (awake),
    .a_new   (a_new),
    .b_new   (b_new),
    .run     (run),
    .last    (last),
    .swallow (swallow),
    .a_cur   (a_cur),
    .b_cur   (b_cur)
  );

  assign mod_hi    = run & swallow;
  assign div_pulse = run & last;
endmodule

// File: rtl/swallow_div_chk.sv
`timescale 1ns/1ps
module swallow_div_chk #(
  parameter int NW  = 17,
  parameter int PL2 = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              mod_hi,
  input logic              div_pulse,
  input logic [PL2-1:0]    a_cur,
  input logic [NW-PL2-1:0] b_cur
);
  localparam int BW = NW - PL2;
  localparam int P  = 1 << PL2;

  logic [BW:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= (BW+1)'(1);
    else if (!run || div_pulse) gap <= (BW+1)'(1);
    else gap <= gap + (BW+1)'(1);
  end

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  // R3
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> (gap == {1'b0, b_cur}));
  // R6
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!div_pulse && !mod_hi));
  // R2
  mod_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mod_hi && !div_pulse) |=> !mod_hi);
  // R5
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div_pulse) |=> ($stable(a_cur) && $stable(b_cur)));
  // R4
  min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (b_cur >= BW'(P)));
endmodule

bind swallow_div swallow_div_chk #(.NW(NW), .PL2(PL2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .mod_hi    (mod_hi),
  .div_pulse (div_pulse),
  .a_cur     (a_cur),
  .b_cur     (b_cur)
);

// File: tb/swallow_div_test.sv
`timescale 1ns/1ps
module swallow_div_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] awk = 2'b11;
  logic [16:0] r0 = 17'd2000, r1 = 17'd500;
  logic mod0, mod1, pul0, pul1, err0, err1;

  always #4 clk = ~clk;

  swallow_div #(.NW(17), .PL2(5)) uut (
    .clk(clk), .rst_n(rst_n), .awake(awk[0]), .ratio_in(r0),
    .mod_hi(mod0), .div_pulse(pul0), .ratio_err(err0));

  swallow_div #(.NW(17), .PL2(4)) uut_lo (
    .clk(clk), .rst_n(rst_n), .awake(awk[1]), .ratio_in(r1),
    .mod_hi(mod1), .div_pulse(pul1), .ratio_err(err1));

  int total = 0, fails = 0;
  int acc[2], hic[2], cyc[2], per[2], hper[2], cper[2], npulse[2];
  int dbl[2], quiet_bad;
  logic [1:0] prevp;
  logic [1:0] modv, pulv;
  assign modv = {mod1, mod0};
  assign pulv = {pul1, pul0};

  localparam int NV = 10;
  localparam int VEC [0:NV-1][0:2] = '{
    '{0, 1024, 1024}, '{0, 131071, 131071}, '{0, 50001, 50001},
    '{0, 1000, 1024}, '{0, 2047, 2047},     '{1, 256, 256},
    '{1, 131071, 131071}, '{1, 7777, 7777}, '{1, 255, 256},
    '{1, 300, 300}};

  // behavioural prescaler: counts oscillator cycles per period
  initial begin
    for (int k = 0; k < 2; k++) begin
      acc[k] = 0; hic[k] = 0; cyc[k] = 0; per[k] = 0;
      hper[k] = 0; cper[k] = 0; npulse[k] = 0; dbl[k] = 0;
    end
    prevp = 2'b00;
  end

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (pulv[k] && prevp[k]) dbl[k] = dbl[k] + 1;
      if (!rst_n || !awk[k]) begin
        acc[k] = 0; hic[k] = 0; cyc[k] = 0;
      end else begin
        acc[k] = acc[k] + (k == 0 ? 32 : 16) + (modv[k] ? 1 : 0);
        hic[k] = hic[k] + (modv[k] ? 1 : 0);
        cyc[k] = cyc[k] + 1;
        if (pulv[k]) begin
          per[k] = acc[k]; hper[k] = hic[k]; cper[k] = cyc[k];
          npulse[k] = npulse[k] + 1;
          acc[k] = 0; hic[k] = 0; cyc[k] = 0;
        end
      end
    end
    prevp = pulv;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_ratio(input int k, input int v);
    @(posedge clk); #2;
    if (k == 0) r0 = 17'(v); else r1 = 17'(v);
  endtask

  task automatic wait_pulses(input int k, input int n);
    int c0;
    c0 = npulse[k];
    while (npulse[k] < c0 + n) @(negedge clk);
  endtask

  task automatic measure(input int k, input int nexp);
    int p;
    p = (k == 0) ? 32 : 16;
    wait_pulses(k, 2);
    check(per[k] == nexp, "R1 period", per[k], nexp);
    check(hper[k] == nexp % p, "R2 swallow cycles", hper[k], nexp % p);
    check(cper[k] == nexp / p, "R3 pulse spacing", cper[k], nexp / p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R7: outputs low during reset
    repeat (3) @(negedge clk);
    check({mod0, mod1, pul0, pul1} == 4'b0, "R7 reset outputs", {mod0, mod1, pul0, pul1}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    check({mod0, mod1, pul0, pul1} == 4'b0, "R7 first cycle after reset", {mod0, mod1, pul0, pul1}, 0);
    measure(0, 2000);
    measure(1, 500);

    // vector table: both bands, min, max, clamp, typical
    for (int i = 0; i < NV; i++) begin
      set_ratio(VEC[i][0], VEC[i][1]);
      #1;
      if (VEC[i][0] == 0)
        check(err0 == (VEC[i][1] != VEC[i][2]), "R4 ratio_err hi band", err0, VEC[i][1] != VEC[i][2]);
      else
        check(err1 == (VEC[i][1] != VEC[i][2]), "R4 ratio_err lo band", err1, VEC[i][1] != VEC[i][2]);
      measure(VEC[i][0], VEC[i][2]);
    end

    // R5: change ratio mid-period
    set_ratio(0, 2048);
    wait_pulses(0, 2);
    repeat (10) @(posedge clk);
    #2; r0 = 17'd3000;
    wait_pulses(0, 1);
    check(per[0] == 2048, "R5 in-flight period keeps old ratio", per[0], 2048);
    wait_pulses(0, 1);
    check(per[0] == 3000, "R5 next period uses new ratio", per[0], 3000);

    // R6: sleep, ratio written while asleep, full first period after wake
    @(posedge clk); #2; awk[0] = 1'b0; r0 = 17'd4000;
    quiet_bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (mod0 || pul0) quiet_bad++;
    end
    check(quiet_bad == 0, "R6 outputs quiet while asleep", quiet_bad, 0);
    @(posedge clk); #2; awk[0] = 1'b1;
    wait_pulses(0, 1);
    check(per[0] == 4000, "R6 first period after wake", per[0], 4000);
    check(cper[0] == 125, "R6 first period spacing", cper[0], 125);

    // R7: reset in mid-operation
    repeat (7) @(posedge clk);
    #2; rst_n = 1'b0;
    @(negedge clk);
    check({mod0, mod1, pul0, pul1} == 4'b0, "R7 outputs in mid-run reset", {mod0, mod1, pul0, pul1}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    measure(0, 4000);

    // R3: never two pulses back to back
    check(dbl[0] == 0 && dbl[1] == 0, "R3 single-cycle pulse", dbl[0] + dbl[1], 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule